// File: doc/BRIEF.md
# Vectored interrupt arbitration unit

This block performs the vector-select step of a small 8-bit controller core. When the core raises a one-cycle select request, the block samples up to fifteen interrupt-active lines and the current 16-bit program counter in that same cycle. It picks the highest-ranked active line. It then builds a vector-table address: the upper byte is the sampled upper PC byte, and the lower byte is an even offset. Rank 1 gets offset FE, each rank below it steps down by two, and the fallback slot E0 is used when no line is active.

The block then reads two bytes through a synchronous program-memory port with one cycle of read latency. The high byte comes from the even address and the low byte from the following odd address. The two bytes are handed to the core as the new program counter, together with a one-cycle done pulse. The block also keeps a non-maskable pending flag. Its source sets the flag, and either a dedicated clear command or reset clears it.

Top module: `vec_arbiter`

## Requirements
- R1: Line i of `irq_act` (bit 0 is the highest rank) selects low byte FE minus 2*i; when several lines are active, the lowest-numbered unmasked one wins.
- R2: Lines 1, 11, 12 and 13 are reserved and never win arbitration, whatever their value.
- R3: With no unmasked line active, the low byte is E0 (the fallback slot after line 14).
- R4: The lines and `pc_i` are sampled in the cycle `sel_req` is accepted; the address upper byte equals the sampled `pc_i[15:8]`, and later changes on `irq_act` or `pc_i` do not alter the fetch.
- R5: One cycle after acceptance, `mem_rd` is high with the even vector address. The next cycle, `mem_rd` is high with that address plus one. The cycle after that, `done` and `pc_wr_en` pulse once, with `pc_wr_data` = {byte read at even address, byte read at odd address}.
- R6: `busy` is high from the cycle after acceptance through the done cycle; a `sel_req` while busy (including the done cycle) is ignored.
- R7: `nmi_pend` goes high the cycle after `nmi_set` and low the cycle after `nmi_clr`; if both are high in one cycle, set wins.
- R8: After reset, `busy`, `done`, `pc_wr_en`, `mem_rd` and `nmi_pend` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_req | input | 1 | Vector-select request from the core |
| irq_act | input | 15 | Interrupt-active lines, bit 0 highest rank |
| pc_i | input | 16 | Current program counter |
| mem_rd | output | 1 | Program-memory read strobe |
| mem_addr | output | 16 | Program-memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| pc_wr_en | output | 1 | Load the program counter |
| pc_wr_data | output | 16 | New program counter value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| nmi_set | input | 1 | Non-maskable pending set |
| nmi_clr | input | 1 | Non-maskable pending clear command |
| nmi_pend | output | 1 | Non-maskable pending flag |

## Verification
Two pairs of functions can fall in the same cycle. The first is a fresh select request arriving during the done cycle of the previous sequence. The bench raises `sel_req` exactly there and expects `busy` to be low one cycle later. The second is a set and a clear of the pending flag in the same cycle. The bench drives both together and expects the flag to be high afterwards. Randomized line patterns are also changed in the cycle right after acceptance, so that any late resampling shows up as a wrong fetch address.

// File: rtl/vec_arbiter.sv
module vec_arbiter #(
  parameter int            NUM_LINES = 15,
  parameter int            DW        = 8,
  parameter int            AW        = 2 * DW,
  parameter logic [14:0]   RSVD_MASK = 15'h3802,
  parameter logic [7:0]    TOP_LO    = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_req,
  input  logic [NUM_LINES-1:0] irq_act,
  input  logic [AW-1:0]        pc_i,
  output logic                 mem_rd,
  output logic [AW-1:0]        mem_addr,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 pc_wr_en,
  output logic [AW-1:0]        pc_wr_data,
  output logic                 busy,
  output logic                 done,
  input  logic                 nmi_set,
  input  logic                 nmi_clr,
  output logic                 nmi_pend
);

  typedef enum logic [1:0] {S_IDLE, S_RD_HI, S_RD_LO, S_LOAD} state_t;

  state_t              state;
  logic [AW-1:0]       vec_q;
  logic [DW-1:0]       hi_q;
  logic [DW-1:0]       sel_lo;
  logic [NUM_LINES-1:0] live;

  assign live = irq_act & ~RSVD_MASK[NUM_LINES-1:0];

  always_comb begin
    sel_lo = TOP_LO - 8'(2 * NUM_LINES);
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (live[i]) sel_lo = TOP_LO - 8'(2 * i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      vec_q <= '0;
      hi_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE:  if (sel_req) begin
                   vec_q <= {pc_i[AW-1:DW], sel_lo};
                   state <= S_RD_HI;
                 end
        S_RD_HI: state <= S_RD_LO;
        S_RD_LO: begin
                   hi_q  <= mem_rdata;
                   state <= S_LOAD;
                 end
        S_LOAD:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nmi_pend <= 1'b0;
    else if (nmi_set) nmi_pend <= 1'b1;
    else if (nmi_clr) nmi_pend <= 1'b0;
  end

  assign busy       = (state != S_IDLE);
  assign mem_rd     = (state == S_RD_HI) || (state == S_RD_LO);
  assign mem_addr   = (state == S_RD_LO) ? (vec_q | AW'(1)) : vec_q;
  assign done       = (state == S_LOAD);
  assign pc_wr_en   = done;
  assign pc_wr_data = {hi_q, mem_rdata};

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_even_then_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_addr[0]) |=> (mem_rd && mem_addr[0]) || done);
  a_r5_pair_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr[0]) |-> mem_addr[AW-1:1] == $past(mem_addr[AW-1:1]));
  a_r1_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[7:5] == 3'b111);
  a_r6_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set |=> nmi_pend);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_clr && !nmi_set) |=> !nmi_pend);

endmodule

// File: tb/vec_arbiter_test.sv
module vec_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, sel_req = 0, nmi_set = 0, nmi_clr = 0;
  logic [14:0] irq_act = '0;
  logic [15:0] pc_i = '0;
  logic        mem_rd, pc_wr_en, busy, done, nmi_pend;
  logic [15:0] mem_addr, pc_wr_data;
  logic [7:0]  mem_rdata = '0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_arbiter uut (.*);

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

  function automatic logic [7:0] exp_lo(logic [14:0] irq);
    logic [14:0] rsvd = 15'b011_1000_0000_0010;
    for (int i = 0; i < 15; i++)
      if (irq[i] && !rsvd[i]) return 8'hFE - 8'(2 * i);
    return 8'hE0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_select(logic [14:0] irq, logic [15:0] pc, string tag);
    logic [15:0] ev;
    ev = {pc[15:8], exp_lo(irq)};
    @(negedge clk);
    irq_act = irq; pc_i = pc; sel_req = 1;
    @(negedge clk);
    irq_act = ~irq; pc_i = ~pc; sel_req = 1;
    check({tag, " R5 rd hi"}, {mem_rd, mem_addr}, {1'b1, ev});
    check("R6 busy", busy, 1);
    @(negedge clk);
    sel_req = 0; irq_act = 15'($urandom);
    check({tag, " R5 rd lo"}, {mem_rd, mem_addr}, {1'b1, ev | 16'h1});
    check("R5 no early done", done, 0);
    @(negedge clk);
    sel_req = 1;
    check({tag, " R5 done"}, {done, pc_wr_en, busy}, 3'b111);
    check({tag, " R1 R4 pc load"}, pc_wr_data,
          {mem_byte(ev), mem_byte(ev | 16'h1)});
    @(negedge clk);
    sel_req = 0;
    check("R6 req on done ignored", {busy, done, mem_rd}, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {busy, done, pc_wr_en, mem_rd, nmi_pend}, 5'b0);
    rst_n = 1;
    @(negedge clk);
    check("R8 after release", {busy, done, mem_rd}, 3'b0);

    run_select(15'h0000, 16'h12AB, "R3 none");
    run_select(15'h3802, 16'h3400, "R2 only reserved");
    run_select(15'h7FFF, 16'hBEEF, "R1 all");
    run_select(15'h4000, 16'h0000, "R1 last line");
    for (int i = 0; i < 15; i++)
      run_select(15'(1) << i, 16'($urandom), "R1 single");
    for (int k = 0; k < 150; k++) begin
      logic [14:0] r = 15'($urandom);
      if (k % 3 == 0) r = r & 15'($urandom) & 15'($urandom);
      run_select(r, 16'($urandom), "R1 R2 random");
    end

    @(negedge clk); nmi_set = 1;
    @(negedge clk); nmi_set = 0;
    check("R7 set", nmi_pend, 1);
    nmi_clr = 1;
    @(negedge clk); nmi_clr = 0;
    check("R7 clear", nmi_pend, 0);
    nmi_set = 1; nmi_clr = 1;
    @(negedge clk); nmi_set = 0; nmi_clr = 0;
    check("R7 set wins", nmi_pend, 1);
    @(negedge clk);
    check("R7 holds", nmi_pend, 1);
    rst_n = 0;
    @(negedge clk);
    check("R8 R7 reset clears", nmi_pend, 0);
    rst_n = 1;

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule